// File: doc/BRIEF.md
# Colour-Filter Gain Index Steering

This block tells a pixel-gain stage, one pixel clock at a time, which of four colour-gain settings applies to the pixel now leaving the sensor. Each gain index stands for one position in a 2x2 Bayer tile. Within a line the index alternates between the two entries of a pair, either 0/1 or 2/3. The frame and line sync inputs decide which pair opens each line, and the readout mode decides how that choice moves from line to line and from field to field. The block keeps its own field counter. A software-side strobe can force the value that counter takes at the next frame.

The block also outputs the 9-bit gain that belongs to the current index, taken from two packed 18-bit gain words. It limits the variable-gain code so that the pixel gain and the variable gain together stay under a ceiling in decibels. The arithmetic for this limit is done in integer milli-dB, with one fixed weight per step for each stage.

Top module: `cfa_gain_steer`

## Requirements
- R1: While reset is asserted, and on the first check after reset is released, `gain_idx` is 0 and `field_num` is 0.
- R2: A sync event is a sampled sync level that is 1 in one cycle and 0 in the next. The pixel after any sync event has an even index (bit 0 = 0). With no event, bit 0 of the index inverts on every clock.
- R3: Mode code 1 (progressive). A frame event sets the field to 0 and selects the 0/1 pair. Each line event then swaps to the other pair.
- R4: Mode code 2 (interlaced). A frame event toggles the field between 0 and 1. Each line then opens with the 0/1 pair in field 0 and the 2/3 pair in field 1.
- R5: Mode code 3 (three-field). A frame event steps the field 0, 1, 2, 0. Field 1 opens with the 2/3 pair and fields 0 and 2 with the 0/1 pair. Each line event swaps the pair. The field is never 3.
- R6: A pulse on `force_wr` stores `force_val`, and the next frame event uses it instead of the normal step. In three-field mode, value 0 gives field 0, 1 gives field 1, and 2 or 3 give field 2. In interlaced mode, a value that maps to 1 gives field 1 and any other value gives field 0. In off and progressive modes the request is used up and the field still becomes 0. A strobe in the same cycle as the frame event applies to that event.
- R7: With mode code 0 (off), or with `pxg_en` low, `gain_idx` is 0 and `gain_sel` is 0.
- R8: `gain_sel` is `gain_pair_a[8:0]` for index 0, `gain_pair_a[17:9]` for index 1, `gain_pair_b[8:0]` for index 2 and `gain_pair_b[17:9]` for index 3.
- R9: The total is 6000 + 35*`vga_code` + 36*`gain_sel` milli-dB. If it is more than 42000, `vga_clipped` is floor((36000 - 36*`gain_sel`)/35) and `clip_flag` is 1. Otherwise `vga_clipped` equals `vga_code` and `clip_flag` is 0. A total of exactly 42000 is not clipped.
- R10: When a frame event and a line event fall in the same cycle, the frame rule alone sets the field and the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame sync level; the event is its falling edge |
| line_sync | input | 1 | Line sync level; the event is its falling edge |
| mode | input | 2 | 0 off, 1 progressive, 2 interlaced, 3 three-field |
| pxg_en | input | 1 | Pixel-gain enable |
| force_wr | input | 1 | One-cycle strobe that stores a forced next field |
| force_val | input | 2 | Forced next-field code |
| gain_pair_a | input | 18 | Gains 0 [8:0] and 1 [17:9] |
| gain_pair_b | input | 18 | Gains 2 [8:0] and 3 [17:9] |
| vga_code | input | 10 | Requested variable-gain code |
| gain_idx | output | 2 | Gain index for the current pixel |
| gain_sel | output | 9 | Gain value for the current index |
| field_num | output | 2 | Current field counter |
| vga_clipped | output | 10 | Variable-gain code after the limit |
| clip_flag | output | 1 | High when the limit changed the code |

## Verification
Two pairs of functions can act in the same cycle: a frame event with a line event, and a frame event with a force strobe. The bench drives both sync levels low on the same clock while in three-field mode, and it also pulses `force_wr` on the clock of a frame fall. It then compares the field, the pair and the even index against a reference built from the frame rule alone. Constrained random traffic makes the same overlaps happen at random, and every cycle is checked against that reference.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
   typedef enum logic [1:0] {
      CGS_OFF  = 2'd0,
      CGS_PROG = 2'd1,
      CGS_INTL = 2'd2,
      CGS_TRI  = 2'd3
   } cgs_mode_e;

   // maps a forced next-field code onto a field number (2 and 3 fold to 2)
   function automatic logic [1:0] cgs_map_force(input logic [1:0] code);
      return (code[1]) ? 2'd2 : code;
   endfunction
endpackage

// File: rtl/cgs_sync_edge.sv
module cgs_sync_edge #(
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lvl,
   output logic [LANES-1:0] fall
);
   generate
      if (LANES < 1) begin : g_bad
         $error("cgs_sync_edge: LANES must be at least 1");
      end
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic held;
         always_ff @(posedge clk) begin
            if (!rst_n) held <= 1'b0;
            else        held <= lvl[k];
         end
         assign fall[k] = held & ~lvl[k];
      end
   endgenerate
endmodule

// File: rtl/cgs_field_seq.sv
module cgs_field_seq
   import cgs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_fall,
   input  logic       line_fall,
   input  logic [1:0] mode,
   input  logic       force_wr,
   input  logic [1:0] force_val,
   output logic [1:0] field,
   output logic       pair,
   output logic       phase
);
   cgs_mode_e  md;
   logic       pend_q;
   logic [1:0] pend_val_q;
   logic       use_force;
   logic [1:0] mapped;
   logic [1:0] nxt_field;
   logic       nxt_pair;
   logic       line_pair;

   assign md        = cgs_mode_e'(mode);
   assign use_force = force_wr | pend_q;
   assign mapped    = cgs_map_force(force_wr ? force_val : pend_val_q);

   always_comb begin
      nxt_field = 2'd0;
      nxt_pair  = 1'b0;
      case (md)
         CGS_INTL: begin
            nxt_field = use_force ? {1'b0, (mapped == 2'd1)} : {1'b0, ~field[0]};
            nxt_pair  = nxt_field[0];
         end
         CGS_TRI: begin
            if (use_force)            nxt_field = mapped;
            else if (field >= 2'd2)   nxt_field = 2'd0;
            else                      nxt_field = field + 2'd1;
            nxt_pair = (nxt_field == 2'd1);
         end
         default: begin
            nxt_field = 2'd0;
            nxt_pair  = 1'b0;
         end
      endcase
   end

   always_comb begin
      case (md)
         CGS_OFF:  line_pair = 1'b0;
         CGS_INTL: line_pair = field[0];
         default:  line_pair = ~pair;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field      <= 2'd0;
         pair       <= 1'b0;
         phase      <= 1'b0;
         pend_q     <= 1'b0;
         pend_val_q <= 2'd0;
      end else if (frame_fall) begin
         field  <= nxt_field;
         pair   <= nxt_pair;
         phase  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (force_wr) begin
            pend_q     <= 1'b1;
            pend_val_q <= force_val;
         end
         if (line_fall) begin
            pair  <= line_pair;
            phase <= 1'b0;
         end else begin
            phase <= ~phase;
         end
      end
   end

   // R2
   alt_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_fall && !line_fall) |=> (phase != $past(phase)));
   // R5
   field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      field != 2'd3);
   // R3
   prog_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_fall && md == CGS_PROG) |=> (field == 2'd0 && !pair && !phase));
   // R6
   force_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_fall && md == CGS_TRI && force_wr && force_val == 2'd1) |=> (field == 2'd1 && pair));
endmodule

// File: rtl/cgs_gain_pick.sv
module cgs_gain_pick #(
   parameter int unsigned GAIN_W = 9,
   localparam int unsigned PAIR_W = 2 * GAIN_W
) (
   input  logic [PAIR_W-1:0] pair_a,
   input  logic [PAIR_W-1:0] pair_b,
   input  logic [1:0]        idx,
   input  logic              active,
   output logic [GAIN_W-1:0] gain
);
   logic [GAIN_W-1:0] lane [4];

   generate
      if (GAIN_W < 1) begin : g_bad
         $error("cgs_gain_pick: GAIN_W must be at least 1");
      end
      for (genvar k = 0; k < 2; k++) begin : g_unpack
         assign lane[k]     = pair_a[k*GAIN_W +: GAIN_W];
         assign lane[k + 2] = pair_b[k*GAIN_W +: GAIN_W];
      end
   endgenerate

   assign gain = active ? lane[idx] : '0;
endmodule

// File: rtl/cgs_gain_clip.sv
module cgs_gain_clip #(
   parameter int unsigned GAIN_W     = 9,
   parameter int unsigned VGA_W      = 10,
   parameter int unsigned OFFSET_MDB = 6000,
   parameter int unsigned VGA_STEP   = 35,
   parameter int unsigned PXG_STEP   = 36,
   parameter int unsigned LIMIT_MDB  = 42000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GAIN_W-1:0] pxg,
   input  logic [VGA_W-1:0]  vga_in,
   output logic [VGA_W-1:0]  vga_out,
   output logic              clipped
);
   localparam int unsigned BUDGET  = LIMIT_MDB - OFFSET_MDB;
   localparam int unsigned PXG_MAX = (1 << GAIN_W) - 1;

   generate
      if (VGA_STEP == 0) begin : g_bad_step
         $error("cgs_gain_clip: VGA_STEP must be nonzero");
      end
      if (LIMIT_MDB < OFFSET_MDB + PXG_MAX * PXG_STEP) begin : g_bad_limit
         $error("cgs_gain_clip: limit must cover the full pixel-gain range");
      end
   endgenerate

   logic [31:0] pxg_cost;
   logic [31:0] vga_cost;
   logic [31:0] room;

   assign pxg_cost = 32'(pxg) * PXG_STEP;
   assign vga_cost = 32'(vga_in) * VGA_STEP;
   assign room     = BUDGET - pxg_cost;
   assign clipped  = (vga_cost + pxg_cost) > BUDGET;
   assign vga_out  = clipped ? VGA_W'(room / VGA_STEP) : vga_in;

   // R9
   total_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (OFFSET_MDB + 32'(vga_out) * VGA_STEP + 32'(pxg) * PXG_STEP) <= LIMIT_MDB);
   // R9
   clip_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clipped |-> (vga_out < vga_in));
endmodule

// File: rtl/cfa_gain_steer.sv
module cfa_gain_steer
   import cgs_pkg::*;
#(
   parameter int unsigned GAIN_W     = 9,
   parameter int unsigned VGA_W      = 10,
   parameter int unsigned OFFSET_MDB = 6000,
   parameter int unsigned VGA_STEP   = 35,
   parameter int unsigned PXG_STEP   = 36,
   parameter int unsigned LIMIT_MDB  = 42000,
   localparam int unsigned PAIR_W    = 2 * GAIN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_sync,
   input  logic              line_sync,
   input  logic [1:0]        mode,
   input  logic              pxg_en,
   input  logic              force_wr,
   input  logic [1:0]        force_val,
   input  logic [PAIR_W-1:0] gain_pair_a,
   input  logic [PAIR_W-1:0] gain_pair_b,
   input  logic [VGA_W-1:0]  vga_code,
   output logic [1:0]        gain_idx,
   output logic [GAIN_W-1:0] gain_sel,
   output logic [1:0]        field_num,
   output logic [VGA_W-1:0]  vga_clipped,
   output logic              clip_flag
);
   logic [1:0] falls;
   logic       pair;
   logic       phase;
   logic       active;

   cgs_sync_edge #(.LANES(2)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   ({line_sync, frame_sync}),
      .fall  (falls)
   );

   cgs_field_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_fall (falls[0]),
      .line_fall  (falls[1]),
      .mode       (mode),
      .force_wr   (force_wr),
      .force_val  (force_val),
      .field      (field_num),
      .pair       (pair),
      .phase      (phase)
   );

   assign active   = pxg_en && (cgs_mode_e'(mode) != CGS_OFF);
   assign gain_idx = active ? {pair, phase} : 2'd0;

   cgs_gain_pick #(.GAIN_W(GAIN_W)) u_pick (
      .pair_a (gain_pair_a),
      .pair_b (gain_pair_b),
      .idx    (gain_idx),
      .active (active),
      .gain   (gain_sel)
   );

   cgs_gain_clip #(
      .GAIN_W     (GAIN_W),
      .VGA_W      (VGA_W),
      .OFFSET_MDB (OFFSET_MDB),
      .VGA_STEP   (VGA_STEP),
      .PXG_STEP   (PXG_STEP),
      .LIMIT_MDB  (LIMIT_MDB)
   ) u_clip (
      .clk     (clk),
      .rst_n   (rst_n),
      .pxg     (gain_sel),
      .vga_in  (vga_code),
      .vga_out (vga_clipped),
      .clipped (clip_flag)
   );

   // R10
   coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (falls[0] && falls[1] && cgs_mode_e'(mode) == CGS_PROG) |=> (field_num == 2'd0 && !pair));
endmodule

// File: tb/tb_cfa_gain_steer.sv
module tb_cfa_gain_steer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_sync = 1'b1;
   logic        line_sync = 1'b1;
   logic [1:0]  mode = 2'd1;
   logic        pxg_en = 1'b1;
   logic        force_wr = 1'b0;
   logic [1:0]  force_val = 2'd0;
   logic [17:0] gain_pair_a = {9'd20, 9'd10};
   logic [17:0] gain_pair_b = {9'd40, 9'd30};
   logic [9:0]  vga_code = 10'd100;
   logic [1:0]  gain_idx;
   logic [8:0]  gain_sel;
   logic [1:0]  field_num;
   logic [9:0]  vga_clipped;
   logic        clip_flag;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   // reference state
   logic [1:0] m_field;
   logic       m_pair, m_phase, m_vs_q, m_hs_q, m_pend;
   logic [1:0] m_pend_val;

   always #2 clk = ~clk;

   cfa_gain_steer dut (
      .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .line_sync(line_sync),
      .mode(mode), .pxg_en(pxg_en), .force_wr(force_wr), .force_val(force_val),
      .gain_pair_a(gain_pair_a), .gain_pair_b(gain_pair_b), .vga_code(vga_code),
      .gain_idx(gain_idx), .gain_sel(gain_sel), .field_num(field_num),
      .vga_clipped(vga_clipped), .clip_flag(clip_flag)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int lane_of(input int idx);
      case (idx)
         0: return int'(gain_pair_a[8:0]);
         1: return int'(gain_pair_a[17:9]);
         2: return int'(gain_pair_b[8:0]);
         default: return int'(gain_pair_b[17:9]);
      endcase
   endfunction

   function automatic int clip_vga(input int p, input int v);
      if (6000 + 35 * v + 36 * p > 42000) return (36000 - 36 * p) / 35;
      return v;
   endfunction

   function automatic string mode_req();
      if (mode == 2'd0 || !pxg_en) return "R7";
      if (mode == 2'd1) return "R3";
      if (mode == 2'd2) return "R4";
      return "R5";
   endfunction

   task automatic model_reset();
      m_field = 2'd0; m_pair = 1'b0; m_phase = 1'b0;
      m_vs_q = 1'b0; m_hs_q = 1'b0; m_pend = 1'b0; m_pend_val = 2'd0;
   endtask

   task automatic model_update();
      logic ff, lf, usep;
      logic [1:0] val, mp;
      ff   = m_vs_q & ~frame_sync;
      lf   = m_hs_q & ~line_sync;
      usep = m_pend | force_wr;
      val  = force_wr ? force_val : m_pend_val;
      mp   = (val >= 2'd2) ? 2'd2 : val;
      if (ff) begin
         case (mode)
            2'd2: begin
               m_field = usep ? ((mp == 2'd1) ? 2'd1 : 2'd0) : (m_field[0] ? 2'd0 : 2'd1);
               m_pair  = m_field[0];
            end
            2'd3: begin
               m_field = usep ? mp : ((m_field == 2'd2) ? 2'd0 : m_field + 2'd1);
               m_pair  = (m_field == 2'd1);
            end
            default: begin m_field = 2'd0; m_pair = 1'b0; end
         endcase
         m_phase = 1'b0; m_pend = 1'b0;
      end else begin
         if (force_wr) begin m_pend = 1'b1; m_pend_val = force_val; end
         if (lf) begin
            if (mode == 2'd0)      m_pair = 1'b0;
            else if (mode == 2'd2) m_pair = m_field[0];
            else                   m_pair = ~m_pair;
            m_phase = 1'b0;
         end else begin
            m_phase = ~m_phase;
         end
      end
      m_vs_q = frame_sync;
      m_hs_q = line_sync;
   endtask

   task automatic compare_all();
      int eidx, eg;
      bit act;
      act  = (mode != 2'd0) && pxg_en;
      eidx = act ? {m_pair, m_phase} : 0;
      eg   = act ? lane_of(eidx) : 0;
      check(mode_req(), int'(gain_idx), eidx);
      check(mode_req(), int'(field_num), int'(m_field));
      check("R8", int'(gain_sel), eg);
      check("R9", int'(vga_clipped), clip_vga(eg, int'(vga_code)));
      check("R9", int'(clip_flag), (clip_vga(eg, int'(vga_code)) != int'(vga_code)) ? 1 : 0);
   endtask

   // called at a falling edge: apply inputs, cross one rising edge, compare
   task automatic step(input logic vs, input logic hs, input logic fw, input logic [1:0] fv);
      frame_sync = vs; line_sync = hs; force_wr = fw; force_val = fv;
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare_all();
   endtask

   task automatic frame_event();
      step(1'b0, 1'b1, 1'b0, 2'd0);
      step(1'b1, 1'b1, 1'b0, 2'd0);
   endtask

   task automatic line_event();
      step(1'b1, 1'b0, 1'b0, 2'd0);
      step(1'b1, 1'b1, 1'b0, 2'd0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", int'(gain_idx), 0);
      check("R1", int'(field_num), 0);
      rst_n = 1'b1;
      check("R1", int'(gain_idx), 0);

      // progressive: frame then lines
      mode = 2'd1;
      step(1'b1, 1'b1, 1'b0, 2'd0);
      frame_event();
      repeat (3) line_event();
      step(1'b1, 1'b0, 1'b0, 2'd0);
      check("R2", int'(gain_idx[0]), 0);
      step(1'b1, 1'b1, 1'b0, 2'd0);
      check("R2", int'(gain_idx[0]), 1);

      // interlaced: field toggles, lines open by field
      mode = 2'd2;
      repeat (3) begin frame_event(); repeat (2) line_event(); end

      // three-field sequence
      mode = 2'd3;
      repeat (4) begin frame_event(); repeat (2) line_event(); end

      // force in three-field: code 3 -> field 2
      step(1'b1, 1'b1, 1'b1, 2'd3);
      repeat (3) step(1'b1, 1'b1, 1'b0, 2'd0);
      frame_event();
      check("R6", int'(field_num), 2);
      // force in same cycle as frame event: code 1 -> field 1, 2/3 pair
      step(1'b0, 1'b1, 1'b1, 2'd1);
      check("R6", int'(field_num), 1);
      check("R6", int'(gain_idx), 2);
      step(1'b1, 1'b1, 1'b0, 2'd0);
      // interlaced force code 2 -> field 0
      mode = 2'd2;
      step(1'b1, 1'b1, 1'b1, 2'd2);
      frame_event();
      check("R6", int'(field_num), 0);

      // coincident frame and line events, three-field from field 0 -> field 1
      mode = 2'd3;
      step(1'b0, 1'b0, 1'b0, 2'd0);
      check("R10", int'(field_num), 1);
      check("R10", int'(gain_idx), 2);
      step(1'b1, 1'b1, 1'b0, 2'd0);

      // off mode and disabled pixel gain
      mode = 2'd0;
      repeat (3) step(1'b1, 1'b1, 1'b0, 2'd0);
      check("R7", int'(gain_idx), 0);
      check("R7", int'(gain_sel), 0);
      mode = 2'd1; pxg_en = 1'b0;
      repeat (3) step(1'b1, 1'b1, 1'b0, 2'd0);
      check("R7", int'(gain_sel), 0);
      pxg_en = 1'b1;

      // clip corners with every lane equal
      gain_pair_a = {9'd125, 9'd125}; gain_pair_b = {9'd125, 9'd125};
      vga_code = 10'd900;
      step(1'b1, 1'b1, 1'b0, 2'd0);
      check("R9", int'(clip_flag), 0);
      check("R9", int'(vga_clipped), 900);
      vga_code = 10'd901;
      step(1'b1, 1'b1, 1'b0, 2'd0);
      check("R9", int'(clip_flag), 1);
      check("R9", int'(vga_clipped), 900);
      gain_pair_a = {9'd511, 9'd511}; gain_pair_b = {9'd511, 9'd511};
      vga_code = 10'd1023;
      step(1'b1, 1'b1, 1'b0, 2'd0);
      check("R9", int'(vga_clipped), 502);
      gain_pair_a = '0; gain_pair_b = '0;
      step(1'b1, 1'b1, 1'b0, 2'd0);
      check("R9", int'(clip_flag), 0);
      check("R9", int'(vga_clipped), 1023);

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         logic vs, hs, fw;
         vs = frame_sync; hs = line_sync;
         if ($urandom_range(0, 199) == 0) vs = ~vs;
         if ($urandom_range(0, 15) == 0)  hs = ~hs;
         fw = ($urandom_range(0, 299) == 0);
         if ($urandom_range(0, 499) == 0) mode = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 49) == 0) begin
            gain_pair_a = 18'($urandom);
            gain_pair_b = 18'($urandom);
            vga_code    = 10'($urandom);
         end
         if ($urandom_range(0, 999) == 0) pxg_en = ~pxg_en;
         step(vs, hs, fw, 2'($urandom_range(0, 3)));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule